// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory that holds 128 bytes. It runs in a system clock domain and watches an oversampled clock line and data line. It responds on the data line only by pulling it low, in the open-drain manner. Each transaction opens with a START. The first byte that follows holds the 7-bit word address and a read/write flag. There is no separate device-select byte. After the slave acknowledges that byte, it either takes in data bytes and stores them, or returns stored bytes one after another for as long as the master keeps acknowledging them.

Written bytes go into a register array that stands in for the nonvolatile store. Within a 4-byte page, the write address advances only in its low bits. A STOP or START that ends a write starts a self-timed busy interval. While that interval runs, the slave leaves its address byte unacknowledged, so the master can poll the slave until the write is complete. Reads advance through the full 7-bit space and wrap around from the last byte to the first.

Top module: `twi_mem_slave`

## Requirements
- R1: During and straight after reset the slave does not pull the data line low. All stored bytes read as 0x00.
- R2: The first byte after a START is sent MSB first as {address[6:0], rw}, where rw=0 means write and rw=1 means read. When the slave is not busy, it pulls the data line low for the whole ninth clock that follows this byte.
- R3: In a write, each data byte is stored at the current address, and the slave acknowledges the byte on the ninth clock.
- R4: After each stored byte, address bits [1:0] step up by one modulo 4 and bits [6:2] stay the same, so a fifth byte written to a page overwrites the first.
- R5: In a read, the slave acknowledges the address byte and then sends the stored byte at that address, MSB first.
- R6: If the master acknowledges a read byte (data line low on its ninth clock), the address steps up by one and the next byte is sent. Address 127 is followed by address 0.
- R7: If the master does not acknowledge a read byte, the slave stops driving and leaves the data line released on the clocks that follow.
- R8: A START or STOP that comes after at least one stored data byte makes the slave busy for WRITE_CYCLES system clocks. While busy it leaves any address byte unacknowledged. Once the interval ends it acknowledges again.
- R9: A START in the middle of a byte discards the bits received so far and begins address reception afresh.
- R10: A STOP in the middle of a data byte ends the transaction without storing the partial byte and without starting a busy interval.
- R11: The slave changes its data-line drive only while the clock line is low, so the line holds steady during every high clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_drive_low | output | 1 | When 1, the pad pulls the data line low; when 0, the line is released |

## Verification
The bench first runs directed cases. A write of 6 bytes that starts partway into a page shows whether the page-local increment and the overwrite are correct. A sequential read that crosses from address 127 to 0 separates wrapping over the full address space from wrapping inside a page. A read ended by a NACK over a stored 0x00 shows whether the slave really stops, because a slave that keeps sending would pull the extra clock low. A restart after four address bits and a STOP after four data bits show that partial bytes are thrown away, and that only a completed byte starts the busy interval. Next come seeded random page writes and random sequential reads, each checked against a model of the memory kept in the bench. Every write is followed by polling, and the first poll must be refused.

// File: rtl/twi_pkg.sv
// Package: shared constants and the protocol state type of the serial memory slave.
// Assumes an 8-bit first byte made of a 7-bit word address and one direction bit.
package twi_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting in address and direction bits
        ST_AACK,   // driving ACK for the address byte
        ST_WDATA,  // shifting in a write data byte
        ST_WACK,   // driving ACK for a write data byte
        ST_RDATA,  // driving read data bits
        ST_RACK    // listening to the master's ACK/NACK
    } twi_state_e;
endpackage

// File: rtl/twi_line_sampler.sv
// Module: brings the raw bus lines into the clock domain through two flops each, and
// detects clock-line edges and START/STOP on the synchronized samples.
// Assumes both lines idle high; the sync flops reset to 1 so reset creates no false events.
module twi_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_s, sda_d;

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_d} <= 3'b111;
            {sda_m, sda_s, sda_d} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_d} <= {scl_raw, scl_m, scl_s};
            {sda_m, sda_s, sda_d} <= {sda_raw, sda_m, sda_s};
        end
    end

    assign scl_lvl    = scl_s;
    assign sda_lvl    = sda_s;
    assign scl_rise   = scl_s & ~scl_d;
    assign scl_fall   = ~scl_s & scl_d;
    assign start_seen = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_seen  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_reg_array.sv
// Module: register array standing in for the byte store; one write port and a
// registered read port that follows rd_addr with one cycle of latency.
// Assumes the caller leaves at least two cycles between an address change and its use.
module twi_reg_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Clear on reset, otherwise write one cell and register one read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) cells[wr_addr] <= wr_data;
            rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/twi_write_timer.sv
// Module: self-timed write interval; a kick loads CYCLES and busy holds until it runs out.
// Assumes a kick while busy restarts the full interval.
module twi_write_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] remain;

    // Countdown of the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (kick)          remain <= LOAD;
        else if (remain != '0)  remain <= remain - ONE;
    end

    assign busy = (remain != '0);

    // R8: busy only starts from a kick
    assert_busy_from_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(kick));
endmodule

// File: rtl/twi_mem_slave.sv
// Module: top of the two-wire serial memory slave. Decodes the address byte, serves
// writes with page-local address stepping and sequential reads with full wrap, and
// withholds the address ACK while the write timer is busy.
// Assumes several system clocks per bus phase; drives the data line only as a pull-low.
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int PAGE_W       = 2,
    parameter int WRITE_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);
    localparam logic [PAGE_W-1:0] PG_ONE  = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] AD_ONE  = ADDR_W'(1);
    localparam logic [3:0]        BITS_ALL = 4'd8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
    logic busy, kick, wr_fire;
    logic [BYTE_W-1:0] rd_data;

    twi_state_e        st;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic              mack;
    logic              wrote;

    twi_line_sampler u_lines (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    twi_reg_array #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_addr(addr), .wr_data(sh),
        .rd_addr(addr), .rd_data(rd_data)
    );

    twi_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
    );

    // A complete data byte is stored on the falling clock that ends its eighth bit.
    assign wr_fire = (st == ST_WDATA) && scl_fall && (cnt == BITS_ALL);
    // A bus condition that ends a write with stored data starts the write interval.
    assign kick    = (start_seen || stop_seen) && wrote;

    // Protocol sequencer: bit counting, address handling and data-line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; addr <= '0;
            rw <= 1'b0; mack <= 1'b0; wrote <= 1'b0; sda_drive_low <= 1'b0;
        end else if (start_seen) begin
            st <= ST_ADDR; cnt <= '0; wrote <= 1'b0; sda_drive_low <= 1'b0;
        end else if (stop_seen) begin
            st <= ST_IDLE; wrote <= 1'b0; sda_drive_low <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: begin
                    if (scl_rise && cnt != BITS_ALL) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == BITS_ALL) begin
                        if (busy) begin
                            st <= ST_IDLE;
                        end else begin
                            addr <= sh[BYTE_W-1:1];
                            rw   <= sh[0];
                            sda_drive_low <= 1'b1;
                            st   <= ST_AACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            tx  <= rd_data;
                            sda_drive_low <= ~rd_data[BYTE_W-1];
                            cnt <= 4'd1;
                            st  <= ST_RDATA;
                        end else begin
                            sda_drive_low <= 1'b0;
                            cnt <= '0;
                            st  <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && cnt != BITS_ALL) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end else if (wr_fire) begin
                        addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
                        wrote <= 1'b1;
                        sda_drive_low <= 1'b1;
                        st <= ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        sda_drive_low <= 1'b0;
                        cnt <= '0;
                        st  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt != BITS_ALL) begin
                            tx  <= {tx[BYTE_W-2:0], 1'b0};
                            sda_drive_low <= ~tx[BYTE_W-2];
                            cnt <= cnt + 4'd1;
                        end else begin
                            sda_drive_low <= 1'b0;
                            st <= ST_RACK;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                        if (!sda_lvl) addr <= addr + AD_ONE;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx  <= rd_data;
                            sda_drive_low <= ~rd_data[BYTE_W-1];
                            cnt <= 4'd1;
                            st  <= ST_RDATA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: reset releases the line
    assert_released_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !sda_drive_low);

    // R11: drive changes only during the low clock phase
    assert_drive_in_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_lvl);

    // R8: no address ACK while the write interval runs
    assert_no_ack_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK) |-> !busy);

    // R4: a stored byte never moves the page bits
    assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

    // R7: idle slave leaves the line released
    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_drive_low);
endmodule

// File: tb/test_twi_mem_slave.sv
// Bench: seeded random page writes and sequential reads mixed with directed corners,
// checked against a memory model kept in the bench.
module test_twi_mem_slave;
    localparam int HALF = 8;
    localparam int WRC  = 400;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, m_scl, m_sda, sda_drive_low;
    wire  sda_line = m_sda & ~sda_drive_low;

    twi_mem_slave #(.PAGE_W(2), .WRITE_CYCLES(WRC)) i_twi_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [128];
    logic [7:0] wbuf [8];

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] page_next(logic [6:0] a);
        return {a[6:2], a[1:0] + 2'd1};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(bit b);
        m_sda = b; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic read_bit(output bit b, output bit steady);
        bit s1;
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF / 2);
        s1 = sda_line; tick(HALF / 2);
        b = sda_line;
        steady = (s1 == b);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(logic [7:0] v, output bit ack);
        bit b, s;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(b, s);
        ack = !b;
    endtask

    task automatic read_byte(bit give_ack, output logic [7:0] v, output bit steady);
        bit b, s;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b, s);
            v[i] = b;
            if (!s) steady = 1'b0;
        end
        send_bit(!give_ack);
    endtask

    // Poll with empty write transactions until acknowledged; returns the first answer.
    task automatic poll_ready(output bit first_ack);
        bit ack;
        int polls = 0;
        do begin
            bus_start();
            send_byte(8'h00, ack);
            bus_stop();
            if (polls == 0) first_ack = ack;
            polls++;
        end while (!ack && polls < 40);
        chk(ack, "R8 ready after interval", ack, 1);
    endtask

    task automatic do_write(logic [6:0] a, int n, output bit first_ack);
        bit ack;
        logic [6:0] p = a;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk(ack, "R2 write address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);
            chk(ack, "R3 data byte ack", ack, 1);
            model[p] = wbuf[k];
            p = page_next(p);
        end
        bus_stop();
        poll_ready(first_ack);
    endtask

    task automatic do_read(logic [6:0] a, int n);
        bit ack, st, all_st;
        logic [7:0] v;
        logic [6:0] p = a;
        all_st = 1'b1;
        bus_start();
        send_byte({a, 1'b1}, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, v, st);
            chk(v == model[p], (k == 0) ? "R5 read data" : "R6 sequential data", v, model[p]);
            if (!st) all_st = 1'b0;
            p = p + 7'd1;
        end
        chk(all_st, "R11 line steady while clock high", all_st, 1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        bit fa, ack, b, s;
        logic [7:0] v;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        sd = $urandom(32'd2024);
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        tick(5);
        chk(!sda_drive_low, "R1 released in reset", sda_drive_low, 0);
        rst_n = 1'b1;
        tick(5);
        chk(!sda_drive_low && sda_line, "R1 released after reset", sda_drive_low, 0);
        do_read(7'h33, 1);

        // Byte write at the top address, then read back (R3, R5); first poll refused (R8).
        wbuf[0] = 8'hA5;
        do_write(7'h7F, 1, fa);
        chk(!fa, "R8 first poll refused", fa, 0);
        do_read(7'h7F, 1);

        // Six bytes into page 0x10..0x13 starting at 0x12 wraps within the page (R4).
        for (int k = 0; k < 6; k++) wbuf[k] = 8'h60 + 8'(k);
        do_write(7'h12, 6, fa);
        chk(!fa, "R8 first poll refused", fa, 0);
        do_read(7'h10, 4);
        chk(model[7'h12] == 8'h64, "R4 overwrite model", model[7'h12], 8'h64);

        // Sequential read across the 127 -> 0 boundary (R6).
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(7'h00, 2, fa);
        do_read(7'h7E, 4);

        // NACK ends the read: next clock over a stored 0x00 stays high (R7).
        bus_start();
        send_byte({7'h41, 1'b1}, ack);
        read_byte(1'b0, v, s);
        chk(v == 8'h00, "R7 data before NACK", v, 0);
        read_bit(b, s);
        chk(b == 1'b1, "R7 released after NACK", b, 1);
        bus_stop();

        // START in mid-byte restarts address reception (R9).
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte({7'h7F, 1'b1}, ack);
        chk(ack, "R9 ack after restart", ack, 1);
        read_byte(1'b0, v, s);
        chk(v == 8'hA5, "R9 data after restart", v, 8'hA5);
        bus_stop();

        // STOP in mid data byte stores nothing and starts no busy interval (R10).
        bus_start();
        send_byte({7'h50, 1'b0}, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        bus_start();
        send_byte({7'h50, 1'b1}, ack);
        chk(ack, "R10 no busy after partial byte", ack, 1);
        read_byte(1'b0, v, s);
        chk(v == model[7'h50], "R10 partial byte not stored", v, model[7'h50]);
        bus_stop();

        // Seeded random page writes and sequential reads.
        for (int t = 0; t < 16; t++) begin
            logic [6:0] a = 7'($urandom % 128);
            int n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(a, n, fa);
            chk(!fa, "R8 first poll refused", fa, 0);
        end
        for (int t = 0; t < 16; t++) begin
            logic [6:0] a = 7'($urandom % 128);
            do_read(a, 1 + int'($urandom % 5));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule